// File: doc/BRIEF.md
# Four-bit accumulator processor core

This core is a small processor with a 4-bit accumulator and separate program and data paths. It reads 8-bit instruction words from a program memory outside the block. The memory is addressed by a 4-bit program counter, which the core drives out on the lower half of a bidirectional bus. The upper half of that bus is a 4-bit input port, and the core reads it with the IN instruction.

Each instruction uses exactly two clock cycles. In the fetch cycle the core presents the PC and captures the instruction word into its instruction register. In the execute cycle it updates the accumulator, the carry and zero flags and the PC. A phase bit on the status output shows which cycle is in progress, so a memory controller can line up its replies with the core. The status byte also carries the accumulator, both flags and a halted indication.

The HLT instruction stops the core. After that the core holds all of its state until the next reset. Internally, a control unit turns the decoded opcode, the flags and the phase into a small set of write strobes. The datapath owns the PC, the instruction register, the accumulator, the flags and the ALU.

Top module: `acc4Cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears the PC, the accumulator, both flags, the halted bit and the instruction register. It also sets the phase to fetch (0).
- R2: When the core is not halted, the phase bit alternates 0,1,0,1 on every edge. The instruction word is captured only on the edge that ends phase 0. The PC, the accumulator and the flags change only on the edge that ends phase 1.
- R3: The instruction register holds the opcode in bits [7:4] and the operand in bits [3:0]. The opcodes are: 0 NOP, 1 LDI, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 SHL, 9 SHR, A JMP, B JZ, C JC, D JNZ, E IN, F HLT.
- R4: ADD computes the accumulator plus the operand modulo 16. Carry receives bit 4 of the 5-bit sum, and zero is set when the 4-bit result is 0.
- R5: SUB computes the accumulator minus the operand modulo 16. Carry is 1 exactly when the accumulator is less than the operand (a borrow), and zero follows the result.
- R6: LDI, AND, OR, XOR, NOT and IN write the accumulator and the zero flag and leave carry unchanged. LDI loads the operand and IN loads the input port. The other four apply their bitwise operation.
- R7: SHL moves the old accumulator bit 3 into carry and shifts left, filling with 0. SHR moves the old bit 0 into carry and shifts right, filling with 0. Both update zero.
- R8: NOP, JMP, JZ, JC, JNZ and HLT leave both flags and the accumulator unchanged.
- R9: JMP always loads the PC with the operand. JZ loads it when zero=1, JC when carry=1 and JNZ when zero=0. When the condition fails, the PC increments.
- R10: The PC increments modulo 16, so it wraps from 15 to 0.
- R11: When HLT executes, the halted bit is set and the PC stays at the address of the HLT. The phase stays at 1. Until reset, the PC, the accumulator, the flags and the phase hold, whatever arrives on the instruction and port inputs.
- R12: `statusOut[3:0]` is the accumulator and `statusOut[4]` is carry. `statusOut[5]` is zero, `statusOut[6]` is halted and `statusOut[7]` is phase. `bidirOut[3:0]` is the PC and `bidirOut[7:4]` is 0. `bidirOe` is fixed at 8'h0F. The input port is `bidirIn[7:4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrIn | input | 8 | Instruction word from program memory |
| bidirIn | input | 8 | Bidirectional bus input side; bits [7:4] form the input port |
| statusOut | output | 8 | Accumulator, carry, zero, halted, phase |
| bidirOut | output | 8 | Bidirectional bus output side; bits [3:0] carry the PC |
| bidirOe | output | 8 | Output enables for the bidirectional bus, constant 8'h0F |

## Verification
The conditional branches are the hardest cases to reach, because each one depends on flags left by earlier instructions. Each test therefore loads a program into a memory model in the bench, and the program sets the flags on purpose before each branch. Every path that the branch should not take leads to a HLT at a different address. The final PC then shows which way each branch went. The halt freeze is checked after the core has halted: the bench changes the memory contents and the port value and confirms that the status byte and the PC do not move. The PC wrap is reached with a jump to address 14 that then falls through addresses 15 and 0.

// File: rtl/acc4Pkg.sv
package acc4Pkg;
  // Accumulator and address widths; the operand field serves both, so they match.
  parameter int unsigned DataW = 4;
  parameter int unsigned AddrW = DataW;
  parameter int unsigned OpW   = 4;
  localparam int unsigned InstrW  = OpW + DataW;
  localparam int unsigned StatusW = DataW + 4;
  localparam int unsigned BusW    = AddrW + DataW;

  typedef enum logic [OpW-1:0] {
    OP_NOP = 4'h0, OP_LDI = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_AND = 4'h4, OP_OR  = 4'h5, OP_XOR = 4'h6, OP_NOT = 4'h7,
    OP_SHL = 4'h8, OP_SHR = 4'h9, OP_JMP = 4'hA, OP_JZ  = 4'hB,
    OP_JC  = 4'hC, OP_JNZ = 4'hD, OP_IN  = 4'hE, OP_HLT = 4'hF
  } opcode_t;

  typedef struct packed {
    logic irLoad;     // capture instruction word
    logic accWe;      // write ALU result to accumulator
    logic carryWe;    // write ALU carry
    logic zeroWe;     // write zero flag from ALU result
    logic pcAdvance;  // update PC this cycle
    logic pcJump;     // with pcAdvance: load operand instead of increment
  } ctrlStrobes_t;
endpackage

// File: rtl/acc4Alu.sv
module acc4Alu
  import acc4Pkg::*;
#(
  parameter int unsigned W = DataW
) (
  input  opcode_t        op,
  input  logic [W-1:0]   accIn,
  input  logic [W-1:0]   operand,
  input  logic [W-1:0]   portIn,
  output logic [W-1:0]   result,
  output logic           carryOut
);
  logic [W:0] wideSum;
  logic [W:0] wideDiff;

  always_comb begin
    wideSum  = {1'b0, accIn} + {1'b0, operand};
    wideDiff = {1'b0, accIn} - {1'b0, operand};
    result   = accIn;
    carryOut = 1'b0;
    unique case (op)
      OP_LDI: result = operand;
      OP_ADD: begin result = wideSum[W-1:0];  carryOut = wideSum[W];  end
      OP_SUB: begin result = wideDiff[W-1:0]; carryOut = wideDiff[W]; end
      OP_AND: result = accIn & operand;
      OP_OR:  result = accIn | operand;
      OP_XOR: result = accIn ^ operand;
      OP_NOT: result = ~accIn;
      OP_SHL: begin result = {accIn[W-2:0], 1'b0}; carryOut = accIn[W-1]; end
      OP_SHR: begin result = {1'b0, accIn[W-1:1]}; carryOut = accIn[0];   end
      OP_IN:  result = portIn;
      default: result = accIn;
    endcase
  end
endmodule

// File: rtl/acc4Datapath.sv
module acc4Datapath
  import acc4Pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       ctl,
  input  logic [InstrW-1:0]  instrIn,
  input  logic [DataW-1:0]   portIn,
  output opcode_t            opcode,
  output logic [DataW-1:0]   accQ,
  output logic               carryQ,
  output logic               zeroQ,
  output logic [AddrW-1:0]   pcQ
);
  logic [InstrW-1:0] irQ;
  logic [DataW-1:0]  operand;
  logic [DataW-1:0]  aluResult;
  logic              aluCarry;

  assign opcode  = opcode_t'(irQ[InstrW-1 -: OpW]);
  assign operand = irQ[DataW-1:0];

  acc4Alu #(.W(DataW)) i_alu (
    .op(opcode), .accIn(accQ), .operand(operand), .portIn(portIn),
    .result(aluResult), .carryOut(aluCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irQ    <= '0;
      accQ   <= '0;
      carryQ <= 1'b0;
      zeroQ  <= 1'b0;
      pcQ    <= '0;
    end else begin
      if (ctl.irLoad)  irQ    <= instrIn;
      if (ctl.accWe)   accQ   <= aluResult;
      if (ctl.carryWe) carryQ <= aluCarry;
      if (ctl.zeroWe)  zeroQ  <= (aluResult == '0);
      if (ctl.pcAdvance) pcQ <= ctl.pcJump ? operand : pcQ + 1'b1;
    end
  end

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl.irLoad |=> $stable(irQ));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl.pcAdvance |=> $stable(pcQ));
  assert_carry_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.carryWe |=> $stable(carryQ));
  assert_zero_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.zeroWe |=> $stable(zeroQ));
  assert_zero_track_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.zeroWe && ctl.accWe) |=> (zeroQ == (accQ == '0)));
endmodule

// File: rtl/acc4Ctrl.sv
module acc4Ctrl
  import acc4Pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  opcode_t       opcode,
  input  logic          carryQ,
  input  logic          zeroQ,
  output ctrlStrobes_t  strobes,
  output logic          phaseQ,
  output logic          haltedQ
);
  logic fetchNow, execNow, isHlt, takeBranch, writesAcc, writesCarry;

  always_comb begin
    fetchNow    = !haltedQ && !phaseQ;
    execNow     = !haltedQ && phaseQ;
    isHlt       = (opcode == OP_HLT);
    takeBranch  = 1'b0;
    writesAcc   = 1'b0;
    writesCarry = 1'b0;
    unique case (opcode)
      OP_LDI, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_IN: writesAcc = 1'b1;
      OP_ADD, OP_SUB, OP_SHL, OP_SHR: begin writesAcc = 1'b1; writesCarry = 1'b1; end
      OP_JMP: takeBranch = 1'b1;
      OP_JZ:  takeBranch = zeroQ;
      OP_JC:  takeBranch = carryQ;
      OP_JNZ: takeBranch = !zeroQ;
      default: ;
    endcase
    strobes.irLoad    = fetchNow;
    strobes.accWe     = execNow && writesAcc;
    strobes.zeroWe    = execNow && writesAcc;
    strobes.carryWe   = execNow && writesCarry;
    strobes.pcAdvance = execNow && !isHlt;
    strobes.pcJump    = takeBranch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ  <= 1'b0;
      haltedQ <= 1'b0;
    end else if (fetchNow) begin
      phaseQ <= 1'b1;
    end else if (execNow) begin
      if (isHlt) haltedQ <= 1'b1;
      else       phaseQ  <= 1'b0;
    end
  end

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (!haltedQ && !(phaseQ && opcode == OP_HLT)) |=> (phaseQ != $past(phaseQ)));
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    haltedQ |=> (haltedQ && phaseQ));
  assert_halt_entry_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(haltedQ) |-> $past(phaseQ));
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.irLoad, strobes.pcAdvance}));
endmodule

// File: rtl/acc4Cpu.sv
module acc4Cpu
  import acc4Pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [InstrW-1:0]   instrIn,
  input  logic [BusW-1:0]     bidirIn,
  output logic [StatusW-1:0]  statusOut,
  output logic [BusW-1:0]     bidirOut,
  output logic [BusW-1:0]     bidirOe
);
  ctrlStrobes_t     strobes;
  opcode_t          opcode;
  logic [DataW-1:0] accVal;
  logic [AddrW-1:0] pcVal;
  logic             carryVal, zeroVal, phaseVal, haltedVal;
  logic             unusedLowIn;

  assign unusedLowIn = ^bidirIn[AddrW-1:0];

  acc4Ctrl i_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .carryQ(carryVal), .zeroQ(zeroVal),
    .strobes(strobes), .phaseQ(phaseVal), .haltedQ(haltedVal)
  );

  acc4Datapath i_datapath (
    .clk(clk), .rst(rst), .ctl(strobes), .instrIn(instrIn),
    .portIn(bidirIn[BusW-1:AddrW]), .opcode(opcode), .accQ(accVal),
    .carryQ(carryVal), .zeroQ(zeroVal), .pcQ(pcVal)
  );

  assign statusOut = {phaseVal, haltedVal, zeroVal, carryVal, accVal};
  assign bidirOut  = {{DataW{1'b0}}, pcVal};
  assign bidirOe   = {{DataW{1'b0}}, {AddrW{1'b1}}};

  assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    haltedVal |=> ($stable(statusOut) && $stable(bidirOut)));
endmodule

// File: tb/test_acc4Cpu.sv
module test_acc4Cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instrIn;
  logic [7:0] bidirIn = 8'h00;
  logic [7:0] statusOut, bidirOut, bidirOe;
  logic [7:0] rom [16];
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;
  assign instrIn = rom[bidirOut[3:0]];

  acc4Cpu i_acc4Cpu (
    .clk(clk), .rst(rst), .instrIn(instrIn), .bidirIn(bidirIn),
    .statusOut(statusOut), .bidirOut(bidirOut), .bidirOe(bidirOe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fillHalt();
    for (int i = 0; i < 16; i++) rom[i] = 8'hF0;
  endtask

  task automatic resetCore();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runToHalt();
    int n = 0;
    while (!statusOut[6] && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expectEnd(input string tag, input int acc, input int c, input int z, input int pc);
    check({tag, " halted R11"}, statusOut[6], 1);
    check({tag, " phase R11"}, statusOut[7], 1);
    check({tag, " acc"}, statusOut[3:0], acc);
    check({tag, " carry"}, statusOut[4], c);
    check({tag, " zero"}, statusOut[5], z);
    check({tag, " pc"}, bidirOut[3:0], pc);
  endtask

  task automatic testReset();
    fillHalt();
    rom[0] = 8'h15;  // LDI 5
    rom[1] = 8'h00;
    resetCore();
    check("R1 status after reset", statusOut, 8'h00);
    check("R1 pc after reset", bidirOut, 8'h00);
    check("R12 output enables", bidirOe, 8'h0F);
    @(negedge clk);
    check("R2 phase after fetch", statusOut[7], 1);
    check("R2 pc held in execute", bidirOut[3:0], 0);
    check("R2 acc not yet written", statusOut[3:0], 0);
    @(negedge clk);
    check("R2 phase back to fetch", statusOut[7], 0);
    check("R2 pc after execute", bidirOut[3:0], 1);
    check("R6 LDI value", statusOut[3:0], 5);
  endtask

  task automatic testAdd();
    fillHalt();
    rom[0] = 8'h13; rom[1] = 8'h24;  // 3+4
    resetCore(); runToHalt();
    expectEnd("R4 add no carry", 7, 0, 0, 2);
    fillHalt();
    rom[0] = 8'h18; rom[1] = 8'h28;  // 8+8 = 16
    resetCore(); runToHalt();
    expectEnd("R4 add carry to zero", 0, 1, 1, 2);
  endtask

  task automatic testSub();
    fillHalt();
    rom[0] = 8'h13; rom[1] = 8'h35;  // 3-5 borrow
    resetCore(); runToHalt();
    expectEnd("R5 sub borrow", 14, 1, 0, 2);
    fillHalt();
    rom[0] = 8'h19; rom[1] = 8'h28; rom[2] = 8'h15; rom[3] = 8'h35;
    resetCore(); runToHalt();
    expectEnd("R5 sub equal clears carry", 0, 0, 1, 4);
  endtask

  task automatic testLogic();
    // R3: opcodes 4..7 decoded from bits [7:4]
    fillHalt();
    rom[0] = 8'h1C; rom[1] = 8'h4A; rom[2] = 8'h51; rom[3] = 8'h6F; rom[4] = 8'h70;
    resetCore(); runToHalt();
    expectEnd("R6 R3 logic chain", 9, 0, 0, 5);
    fillHalt();
    rom[0] = 8'h19; rom[1] = 8'h28; rom[2] = 8'h15; rom[3] = 8'hE0;
    bidirIn = 8'h03;  // low nibble must be ignored
    resetCore(); runToHalt();
    expectEnd("R6 IN port zero keeps carry", 0, 1, 1, 4);
  endtask

  task automatic testShift();
    fillHalt();
    rom[0] = 8'h19; rom[1] = 8'h80;
    resetCore(); runToHalt();
    expectEnd("R7 SHL", 2, 1, 0, 2);
    fillHalt();
    rom[0] = 8'h19; rom[1] = 8'h80; rom[2] = 8'h90; rom[3] = 8'h90;
    resetCore(); runToHalt();
    expectEnd("R7 SHR chain", 0, 1, 1, 4);
  endtask

  task automatic testFlagsHeld();
    fillHalt();
    rom[0] = 8'h19; rom[1] = 8'h28; rom[2] = 8'h10; rom[3] = 8'h00; rom[4] = 8'hA6;
    resetCore(); runToHalt();
    expectEnd("R8 NOP JMP keep flags", 0, 1, 1, 6);
  endtask

  task automatic testBranch();
    fillHalt();
    rom[0] = 8'h10; rom[1] = 8'hB4; rom[4] = 8'hD2; rom[5] = 8'h19;
    rom[6] = 8'h28; rom[7] = 8'hC9; rom[9] = 8'hE0; rom[10] = 8'hAC;
    bidirIn = 8'h60;
    resetCore(); runToHalt();
    expectEnd("R9 branch chain", 6, 1, 0, 12);
    check("R12 upper bus out zero", bidirOut[7:4], 0);
    // halt freeze: change inputs, state must hold
    bidirIn = 8'hA0;
    for (int i = 0; i < 16; i++) rom[i] = 8'h1F;
    repeat (10) @(negedge clk);
    check("R11 status frozen", statusOut, 8'hC6 | 8'h10);
    check("R11 pc frozen", bidirOut[3:0], 12);
  endtask

  task automatic testWrap();
    fillHalt();
    rom[0] = 8'hDE; rom[14] = 8'h10; rom[15] = 8'h00;
    resetCore(); runToHalt();
    expectEnd("R10 pc wrap", 0, 0, 1, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testAdd();
    testSub();
    bidirIn = 8'h00;
    testLogic();
    testShift();
    testFlagsHeld();
    testBranch();
    testWrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule